// File: doc/BRIEF.md
# Manchester Pulse Width Classifier

This block sits behind a raw, asynchronous serial line that carries Manchester-coded data. It brings the line into the system clock domain and watches for a start qualifier: a high level held for a long time. Until that qualifier has been seen, nothing is classified.

Once the qualifier has been seen, the block measures every run between two transitions of the synchronized line. It sorts each run into one of four classes: a single-length or double-length high, or a single-length or double-length low. Each class is delivered as a one-hot symbol on a valid/ready stream to a downstream decoder. A run whose length fits no window raises a one-cycle error pulse and produces no symbol.

The output stream holds one symbol at a time. While the consumer keeps ready low, the symbol and valid stay frozen. A run that completes during that time is dropped and flagged, because the line cannot be paused.

Top module: `mrc_top`

## Requirements
- R1: The line is sampled only on the rising clock edge through a two-flop synchronizer. A level held on the line for N clock cycles is measured as a run of exactly N cycles.
- R2: The start flag sets once the synchronized line has been high for QUAD_LEN consecutive cycles. A high run of QUAD_LEN-1 cycles does not set it. Any low cycle clears the high-run count, so two short high runs do not add up.
- R3: Once set, the start flag stays asserted until reset, whatever the line does.
- R4: No run produces a symbol or an error before the start flag is set. The run that is still in progress when the flag sets (the long high) is not classified either.
- R5: A run of length L is a single when SINGLE_MIN ≤ L ≤ SINGLE_MAX, and a double when DOUBLE_MIN ≤ L ≤ DOUBLE_MAX. The symbol is one-hot:
  - bit 0 is a single high;
  - bit 1 is a double high;
  - bit 2 is a single low;
  - bit 3 is a double low.
- R6: A classified run whose length lies outside both windows gives a one-cycle pulse on bad_run_o and no symbol.
- R7: The run counter saturates at its all-ones value and never wraps. A very long run is therefore reported as out of window.
- R8: While sym_valid_o is high and sym_ready_i is low, sym_valid_o stays high and sym_o stays unchanged. A transfer happens on a rising edge where both are high.
- R9: A symbol that completes while an earlier one is still waiting to be accepted is discarded, and overrun_o pulses for one cycle. The waiting symbol is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Asynchronous serial line |
| start_seen_o | output | 1 | Sticky start-qualifier flag |
| sym_valid_o | output | 1 | Symbol stream valid |
| sym_ready_i | input | 1 | Symbol stream ready from the consumer |
| sym_o | output | 4 | One-hot run class |
| bad_run_o | output | 1 | One-cycle pulse for an out-of-window run |
| overrun_o | output | 1 | One-cycle pulse for a symbol dropped under back-pressure |

## Verification
The bench builds the block with a single window of 7 to 13 cycles, a double window of 17 to 23 cycles and QUAD_LEN of 45. With these values the run counter is five bits wide. Every window edge, the one-cycle-short start qualifier and counter saturation (a 300-cycle run that would alias to a single if the counter wrapped) all fall within a few hundred cycles. Back-pressure is exercised by holding ready low across several completed runs.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  typedef logic [3:0] sym_t;
  localparam int unsigned SYM_HI_SINGLE = 0;
  localparam int unsigned SYM_HI_DOUBLE = 1;
  localparam int unsigned SYM_LO_SINGLE = 2;
  localparam int unsigned SYM_LO_DOUBLE = 3;
endpackage

// File: rtl/mrc_sync.sv
module mrc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic prev_o,
  output logic edge_o
);
  // chain[0..STAGES-1] synchronize, chain[STAGES] holds previous sample
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= line_i;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign level_o = chain[STAGES-1];
  assign prev_o  = chain[STAGES];
  assign edge_o  = chain[STAGES-1] ^ chain[STAGES];
endmodule

// File: rtl/mrc_start_qual.sv
module mrc_start_qual #(
  parameter int unsigned QUAD_LEN = 45
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic start_o
);
  localparam int unsigned HW = $clog2(QUAD_LEN + 1);
  localparam logic [HW-1:0] HI_LAST = HW'(QUAD_LEN - 1);
  localparam logic [HW-1:0] HI_TOP  = HW'(QUAD_LEN);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      start_o <= 1'b0;
    end else begin
      if (!level_i)             hi_cnt <= '0;
      else if (hi_cnt != HI_TOP) hi_cnt <= hi_cnt + 1'b1;
      if (level_i && hi_cnt == HI_LAST) start_o <= 1'b1;
    end
  end

  AST_START_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> start_o); // R3
  AST_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !level_i |=> hi_cnt == '0); // R2
endmodule

// File: rtl/mrc_run_meter.sv
module mrc_run_meter
  import mrc_pkg::*;
#(
  parameter int unsigned SINGLE_MIN = 7,
  parameter int unsigned SINGLE_MAX = 13,
  parameter int unsigned DOUBLE_MIN = 17,
  parameter int unsigned DOUBLE_MAX = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic prev_i,
  input  logic enable_i,
  output logic sym_stb_o,
  output sym_t sym_o,
  output logic bad_o
);
  localparam int unsigned RUN_W = $clog2(DOUBLE_MAX + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [RUN_W-1:0] S_LO = RUN_W'(SINGLE_MIN);
  localparam logic [RUN_W-1:0] S_HI = RUN_W'(SINGLE_MAX);
  localparam logic [RUN_W-1:0] D_LO = RUN_W'(DOUBLE_MIN);
  localparam logic [RUN_W-1:0] D_HI = RUN_W'(DOUBLE_MAX);

  logic [RUN_W-1:0] run_cnt;
  logic armed, judge, in_single, in_double;
  sym_t code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      armed   <= 1'b0;
    end else begin
      if (edge_i)                run_cnt <= RUN_W'(1);
      else if (run_cnt != RUN_MAX) run_cnt <= run_cnt + 1'b1;
      if (edge_i && enable_i) armed <= 1'b1;
    end
  end

  assign judge     = edge_i && armed;
  assign in_single = (run_cnt >= S_LO) && (run_cnt <= S_HI);
  assign in_double = (run_cnt >= D_LO) && (run_cnt <= D_HI);

  always_comb begin
    code = '0;
    code[SYM_HI_SINGLE] = prev_i  && in_single;
    code[SYM_HI_DOUBLE] = prev_i  && in_double;
    code[SYM_LO_SINGLE] = !prev_i && in_single;
    code[SYM_LO_DOUBLE] = !prev_i && in_double;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_stb_o <= 1'b0;
      sym_o     <= '0;
      bad_o     <= 1'b0;
    end else begin
      sym_stb_o <= judge && (in_single || in_double);
      bad_o     <= judge && !(in_single || in_double);
      if (judge) sym_o <= code;
    end
  end

  AST_RUN_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == RUN_MAX && !edge_i) |=> run_cnt == RUN_MAX); // R7
  AST_NO_EARLY_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb_o || bad_o) |-> armed); // R4
  AST_BAD_XOR_SYM: assert property (@(posedge clk) disable iff (!rst_n)
    !(sym_stb_o && bad_o)); // R6
endmodule

// File: rtl/mrc_out_slot.sv
module mrc_out_slot
  import mrc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_stb_i,
  input  sym_t in_sym_i,
  input  logic ready_i,
  output logic valid_o,
  output sym_t sym_o,
  output logic overrun_o
);
  logic free;
  assign free = !valid_o || ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      sym_o     <= '0;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= in_stb_i && !free;
      if (free) begin
        valid_o <= in_stb_i;
        if (in_stb_i) sym_o <= in_sym_i;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(sym_o))); // R8
  AST_SYM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $countones(sym_o) == 1); // R5
  AST_OVERRUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> valid_o); // R9
endmodule

// File: rtl/mrc_top.sv
module mrc_top
  import mrc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAD_LEN    = 45,
  parameter int unsigned SINGLE_MIN  = 7,
  parameter int unsigned SINGLE_MAX  = 13,
  parameter int unsigned DOUBLE_MIN  = 17,
  parameter int unsigned DOUBLE_MAX  = 23
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic       start_seen_o,
  output logic       sym_valid_o,
  input  logic       sym_ready_i,
  output logic [3:0] sym_o,
  output logic       bad_run_o,
  output logic       overrun_o
);
  logic level, prev, edge_seen, stb;
  sym_t cls;

  mrc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .level_o(level), .prev_o(prev), .edge_o(edge_seen)
  );

  mrc_start_qual #(.QUAD_LEN(QUAD_LEN)) u_start (
    .clk(clk), .rst_n(rst_n), .level_i(level), .start_o(start_seen_o)
  );

  mrc_run_meter #(
    .SINGLE_MIN(SINGLE_MIN), .SINGLE_MAX(SINGLE_MAX),
    .DOUBLE_MIN(DOUBLE_MIN), .DOUBLE_MAX(DOUBLE_MAX)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_seen), .prev_i(prev),
    .enable_i(start_seen_o), .sym_stb_o(stb), .sym_o(cls), .bad_o(bad_run_o)
  );

  mrc_out_slot u_slot (
    .clk(clk), .rst_n(rst_n), .in_stb_i(stb), .in_sym_i(cls),
    .ready_i(sym_ready_i), .valid_o(sym_valid_o), .sym_o(sym_o),
    .overrun_o(overrun_o)
  );
endmodule

// File: tb/mrc_top_tb.sv
module mrc_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic ready = 1'b1;
  logic start_seen, valid, bad, ovr;
  logic [3:0] sym;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] log_q [0:63];
  int n_log = 0;
  int n_bad = 0;
  int n_ovr = 0;

  always #5 clk = ~clk;

  mrc_top #(
    .QUAD_LEN(45), .SINGLE_MIN(7), .SINGLE_MAX(13),
    .DOUBLE_MIN(17), .DOUBLE_MAX(23)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .line_i(line), .start_seen_o(start_seen),
    .sym_valid_o(valid), .sym_ready_i(ready), .sym_o(sym),
    .bad_run_o(bad), .overrun_o(ovr)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid && ready && n_log < 64) begin
        log_q[n_log] = sym;
        n_log++;
      end
      if (bad) n_bad++;
      if (ovr) n_ovr++;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic run(input logic lvl, input int n);
    line = lvl;
    tick(n);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_log(input int idx, input logic [3:0] exp, input string req);
    int a;
    a = (idx < n_log) ? int'(log_q[idx]) : -1;
    check(a == int'(exp), req, a, int'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    line  = 1'b0;
    ready = 1'b1;
    tick(4);
    n_log = 0;
    n_bad = 0;
    n_ovr = 0;
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(start_seen == 1'b0, "R3 reset start flag", start_seen, 0);
    check(valid == 1'b0, "R8 reset valid", valid, 0);
    check(bad == 1'b0 && ovr == 1'b0, "R6 reset pulses", bad | ovr, 0);
  endtask

  task automatic t_start_qualifier();
    do_reset();
    run(1'b1, 44); run(1'b0, 10);
    check(start_seen == 1'b0, "R2 one cycle short", start_seen, 0);
    run(1'b1, 30); run(1'b0, 3); run(1'b1, 30); run(1'b0, 10);
    check(start_seen == 1'b0, "R2 low clears count", start_seen, 0);
    run(1'b1, 45); run(1'b0, 10);
    check(start_seen == 1'b1, "R2 exact length", start_seen, 1);
    check(n_log == 0 && n_bad == 0, "R4 nothing before start", n_log + n_bad, 0);
  endtask

  task automatic t_basic_classes();
    do_reset();
    run(1'b1, 50);
    run(1'b0, 10); run(1'b1, 20); run(1'b0, 20); run(1'b1, 10);
    run(1'b0, 8);
    check(n_log == 4, "R5 symbol count", n_log, 4);
    check_log(0, 4'b0100, "R5 single low");
    check_log(1, 4'b0010, "R5 double high");
    check_log(2, 4'b1000, "R5 double low");
    check_log(3, 4'b0001, "R5 single high");
    check(n_bad == 0, "R4 start run not classified", n_bad, 0);
  endtask

  task automatic t_window_edges();
    do_reset();
    run(1'b1, 50);
    run(1'b0, 7); run(1'b1, 13); run(1'b0, 17); run(1'b1, 23);
    run(1'b0, 6); run(1'b1, 14); run(1'b0, 16); run(1'b1, 24);
    run(1'b0, 10);
    check(n_log == 4, "R1 in-window count", n_log, 4);
    check_log(0, 4'b0100, "R1 length 7");
    check_log(1, 4'b0001, "R1 length 13");
    check_log(2, 4'b1000, "R1 length 17");
    check_log(3, 4'b0010, "R1 length 23");
    check(n_bad == 4, "R6 out-of-window pulses", n_bad, 4);
  endtask

  task automatic t_saturation();
    do_reset();
    run(1'b1, 50);
    run(1'b0, 300); run(1'b1, 10); run(1'b0, 8);
    check(n_bad == 1, "R7 long run flagged", n_bad, 1);
    check(n_log == 1, "R7 no aliased symbol", n_log, 1);
    check_log(0, 4'b0001, "R7 following run");
    check(start_seen == 1'b1, "R3 flag sticky", start_seen, 1);
  endtask

  task automatic t_backpressure();
    do_reset();
    ready = 1'b0;
    run(1'b1, 50);
    run(1'b0, 10); run(1'b1, 10); run(1'b0, 10); run(1'b1, 10);
    run(1'b0, 6);
    check(valid == 1'b1, "R8 valid held", valid, 1);
    check(sym == 4'b0100, "R8 symbol held", sym, 4);
    check(n_log == 0, "R8 no transfer", n_log, 0);
    check(n_ovr == 3, "R9 overrun pulses", n_ovr, 3);
    ready = 1'b1;
    tick(3);
    check(n_log == 1, "R9 one transfer", n_log, 1);
    check_log(0, 4'b0100, "R9 kept symbol");
    check(valid == 1'b0, "R8 valid drops", valid, 0);
  endtask

  initial begin
    t_reset_state();
    t_start_qualifier();
    t_basic_classes();
    t_window_edges();
    t_saturation();
    t_backpressure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule